// File: doc/BRIEF.md
# Truncating Single-Precision Multiplier

This block multiplies two 32-bit single-precision words and delivers a 32-bit product word. It is a deliberately simple datapath: an operand word that is exactly all zeros is passed through as the result, otherwise the sign is the XOR of the operand signs, the biased exponents are summed and corrected by the bias, and the two 24-bit significands (hidden bit restored) are multiplied into a 48-bit product. That product is aligned, normalized by right shifts only, and cut to 23 fraction bits with no rounding. Exponent overflow and underflow wrap modulo 256. Infinities, NaNs and subnormals receive no special handling.

Operands enter on a valid/ready stream and results leave on a valid/ready stream. The pipeline has two register stages. Each stage can advance when it is empty or when the stage after it is advancing. A result presented with `out_valid` high stays on `out_result` unchanged until the consumer raises `out_ready`. When both stages hold data and the consumer stalls, `in_ready` falls, and the producer must hold its operands and `in_valid` until a transfer happens. Transfers take place on rising clock edges where valid and ready are both high. Results leave in the order their operands were accepted.

Top module: `trunc_fmul`

## Requirements
- R1: If either operand word equals 0x00000000, the result is 0x00000000. The word 0x80000000 is not bypassed and goes through the normal path (so 0x80000000 × 0x3F800000 gives 0x80000000).
- R2: Result bit 31 is the XOR of the two operands' bit 31.
- R3: Result bits 30:23 equal (exp_a + exp_b − 127) mod 256 before normalization, where exp is bits 30:23 of each operand.
- R4: Each significand is {1, bits 22:0}. The two are multiplied into a 48-bit product, which is shifted right by 23. So 1.0 × 1.0 and 2.0 × 0.5 both give 0x3F800000.
- R5: After alignment, while any bit at position 24 or above is set, the value shifts right by one and the exponent increments, still modulo 256 (0x7F400000 × 0x40400000 gives 0x00100000).
- R6: Result bits 22:0 are the low 23 bits of the normalized value. Discarded bits never round up (0x3FC00000 × 0x3F800001 gives 0x3FC00001).
- R7: With `out_ready` held high, a result appears on `out_valid` exactly two rising edges after its operands are accepted. One result per cycle is sustained for back-to-back inputs.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_result` hold. When both stages are full under such a stall, `in_ready` is low.
- R9: During and just after reset, `out_valid` is low and `in_ready` is high.
- R10: Results leave in the order their operands were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair is presented |
| in_ready | output | 1 | Block can take an operand pair this cycle |
| in_a | input | 32 | First operand, single-precision word |
| in_b | input | 32 | Second operand, single-precision word |
| out_valid | output | 1 | Result word is presented |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 32 | Truncated product word |

## Verification
The hardest state to reach from the ports is the one where both stages are occupied, the consumer is stalled, and a third operand pair is waiting. Only there can `in_ready` fall, and only there must the held result survive several idle edges. The bench gets there by lowering `out_ready` first and then presenting three pairs on consecutive cycles. It holds that state for several cycles and then releases the stall, checking the values and order of the three results. A second hard corner is an exponent sum that wraps only because of the normalization increment. It is reached with a chosen operand pair whose corrected sum is 255 and whose significand product needs one right shift.

// File: rtl/trunc_fmul_pkg.sv
package trunc_fmul_pkg;
  localparam int EXP_W   = 8;
  localparam int FRAC_W  = 23;
  localparam int WORD_W  = 1 + EXP_W + FRAC_W;
  localparam int MANT_W  = FRAC_W + 1;
  localparam int PROD_W  = 2 * MANT_W;
  localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
  localparam int SHIFT_W = $clog2(PROD_W);

  typedef struct packed {
    logic              zero;
    logic              sign;
    logic [EXP_W-1:0]  exp;
    logic [MANT_W-1:0] mant_a;
    logic [MANT_W-1:0] mant_b;
  } dec_t;

  localparam int DEC_W = $bits(dec_t);
endpackage

// File: rtl/trunc_fmul_decode.sv
module trunc_fmul_decode
  import trunc_fmul_pkg::*;
(
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  output dec_t              dec_o
);
  logic [EXP_W-1:0] exp_a;
  logic [EXP_W-1:0] exp_b;

  assign exp_a = a_i[WORD_W-2 -: EXP_W];
  assign exp_b = b_i[WORD_W-2 -: EXP_W];

  always_comb begin
    dec_o.zero   = (a_i == '0) || (b_i == '0);
    dec_o.sign   = a_i[WORD_W-1] ^ b_i[WORD_W-1];
    // modular sum keeps only EXP_W bits by width
    dec_o.exp    = exp_a + exp_b - EXP_W'(BIAS);
    dec_o.mant_a = {1'b1, a_i[FRAC_W-1:0]};
    dec_o.mant_b = {1'b1, b_i[FRAC_W-1:0]};
  end
endmodule

// File: rtl/trunc_fmul_norm.sv
module trunc_fmul_norm
  import trunc_fmul_pkg::*;
(
  input  logic [PROD_W-1:0] prod_i,
  input  logic [EXP_W-1:0]  exp_i,
  output logic [FRAC_W-1:0] frac_o,
  output logic              lead_o,
  output logic              spill_o,
  output logic [EXP_W-1:0]  exp_o
);
  logic [PROD_W-1:0]  aligned;
  logic [PROD_W-1:0]  scaled;
  logic [SHIFT_W-1:0] amount;

  always_comb begin
    aligned = prod_i >> FRAC_W;
    amount  = '0;
    // highest set bit above the hidden position sets the right shift
    for (int i = MANT_W; i < PROD_W; i++) begin
      if (aligned[i]) amount = SHIFT_W'(i - (MANT_W - 1));
    end
    scaled = aligned >> amount;
  end

  assign frac_o  = scaled[FRAC_W-1:0];
  assign lead_o  = scaled[MANT_W-1];
  assign spill_o = |scaled[PROD_W-1:MANT_W];
  assign exp_o   = exp_i + EXP_W'(amount);
endmodule

// File: rtl/trunc_fmul_slot.sv
module trunc_fmul_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data
);
  assign up_ready = !dn_valid || dn_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dn_valid <= 1'b0;
      dn_data  <= '0;
    end else if (up_ready) begin
      dn_valid <= up_valid;
      if (up_valid) dn_data <= up_data;
    end
  end
endmodule

// File: rtl/trunc_fmul.sv
module trunc_fmul
  import trunc_fmul_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_a,
  input  logic [WORD_W-1:0] in_b,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_result
);
  dec_t              dec_d;
  dec_t              s1_q;
  logic [DEC_W-1:0]  dec_bus;
  logic [DEC_W-1:0]  s1_bus;
  logic              s1_valid;
  logic              s2_load;
  logic              s1_zero;
  logic              s1_sign;
  logic [PROD_W-1:0] prod;
  logic [FRAC_W-1:0] n_frac;
  logic [EXP_W-1:0]  n_exp;
  logic              n_lead;
  logic              n_spill;
  logic [WORD_W-1:0] s2_word;

  trunc_fmul_decode u_decode (
    .a_i   (in_a),
    .b_i   (in_b),
    .dec_o (dec_d)
  );

  assign dec_bus = dec_d;

  trunc_fmul_slot #(.W(DEC_W)) u_slot_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  (dec_bus),
    .dn_valid (s1_valid),
    .dn_ready (s2_load),
    .dn_data  (s1_bus)
  );

  assign s1_q    = dec_t'(s1_bus);
  assign s1_zero = s1_q.zero;
  assign s1_sign = s1_q.sign;
  assign prod    = PROD_W'(s1_q.mant_a) * PROD_W'(s1_q.mant_b);

  trunc_fmul_norm u_norm (
    .prod_i  (prod),
    .exp_i   (s1_q.exp),
    .frac_o  (n_frac),
    .lead_o  (n_lead),
    .spill_o (n_spill),
    .exp_o   (n_exp)
  );

  assign s2_word = s1_zero ? '0 : {s1_sign, n_exp, n_frac};

  trunc_fmul_slot #(.W(WORD_W)) u_slot_res (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (s1_valid),
    .up_ready (s2_load),
    .up_data  (s2_word),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (out_result)
  );
endmodule

// File: rtl/trunc_fmul_chk.sv
module trunc_fmul_chk
  import trunc_fmul_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_result,
  input logic              s1_valid,
  input logic              s2_load,
  input logic              s1_zero,
  input logic              s1_sign,
  input logic              n_lead,
  input logic              n_spill
);
  // R8
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result)));

  // R8
  full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && out_valid && !out_ready) |-> !in_ready);

  // R1
  zero_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s2_load && s1_zero) |=> (out_valid && out_result == '0));

  // R2
  sign_xor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s2_load && !s1_zero) |=> (out_result[WORD_W-1] == $past(s1_sign)));

  // R5
  norm_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && !s1_zero) |-> (n_lead && !n_spill));

  // R7
  out_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(s1_valid));
endmodule

bind trunc_fmul trunc_fmul_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_result (out_result),
  .s1_valid   (s1_valid),
  .s2_load    (s2_load),
  .s1_zero    (s1_zero),
  .s1_sign    (s1_sign),
  .n_lead     (n_lead),
  .n_spill    (n_spill)
);

// File: tb/trunc_fmul_bench.sv
module trunc_fmul_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_a = '0;
  logic [31:0] in_b = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;
  int          n_chk = 0;
  int          n_fail = 0;

  always #4 clk = ~clk;

  trunc_fmul u_trunc_fmul (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_a       (in_a),
    .in_b       (in_b),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_result (out_result)
  );

  function automatic logic [31:0] ref_mul(logic [31:0] a, logic [31:0] b);
    longint unsigned p;
    int e;
    if (a == 32'h0) return a;
    if (b == 32'h0) return b;
    p = longint'({1'b1, a[22:0]}) * longint'({1'b1, b[22:0]});
    p = p >> 23;
    e = (int'(a[30:23]) + int'(b[30:23]) + 256 - 127) % 256;
    while ((p >> 24) != 0) begin
      p = p >> 1;
      e = (e + 1) % 256;
    end
    return {a[31] ^ b[31], e[7:0], p[22:0]};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic one_op(string req, logic [31:0] a, logic [31:0] b, logic [31:0] exp);
    @(negedge clk);
    out_ready = 1'b1;
    in_valid = 1'b1; in_a = a; in_b = b;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, "/R7 not early"}, {31'h0, out_valid}, 32'h0);
    @(negedge clk);
    check({req, "/R7 on time"}, {31'h0, out_valid}, 32'h1);
    check(req, out_result, exp);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 out_valid in reset", {31'h0, out_valid}, 32'h0);
    check("R9 in_ready in reset", {31'h0, in_ready}, 32'h1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 out_valid after reset", {31'h0, out_valid}, 32'h0);
  endtask

  task automatic t_zero();
    one_op("R1 zero a", 32'h0000_0000, 32'hC040_0000, 32'h0000_0000);
    one_op("R1 zero b", 32'h4000_0000, 32'h0000_0000, 32'h0000_0000);
    one_op("R1 neg zero not bypassed", 32'h8000_0000, 32'h3F80_0000, 32'h8000_0000);
  endtask

  task automatic t_sign();
    one_op("R2 neg*pos", 32'hC000_0000, 32'h4040_0000, 32'hC0C0_0000);
    one_op("R2 neg*neg", 32'hC000_0000, 32'hC040_0000, 32'h40C0_0000);
  endtask

  task automatic t_exp_wrap();
    one_op("R3 high wrap", 32'h7F00_0000, 32'h7F00_0000, 32'h3E80_0000);
    one_op("R3 low wrap", 32'h0080_0000, 32'h0080_0000, 32'h4180_0000);
  endtask

  task automatic t_mant();
    one_op("R4 one*one", 32'h3F80_0000, 32'h3F80_0000, 32'h3F80_0000);
    one_op("R4 two*half", 32'h4000_0000, 32'h3F00_0000, 32'h3F80_0000);
    one_op("R4 low bits", 32'h3F80_0001, 32'h3F80_0001, 32'h3F80_0002);
  endtask

  task automatic t_norm();
    one_op("R5 shift once", 32'h3FC0_0000, 32'h3FC0_0000, 32'h4010_0000);
    one_op("R5 wrap on increment", 32'h7F40_0000, 32'h4040_0000, 32'h0010_0000);
  endtask

  task automatic t_trunc();
    one_op("R6 no round up", 32'h3FC0_0000, 32'h3F80_0001, 32'h3FC0_0001);
    one_op("R6 all ones", 32'h3FFF_FFFF, 32'h3FFF_FFFF, 32'h407F_FFFE);
  endtask

  task automatic t_stream();
    logic [31:0] va [6] = '{32'h4049_0FDB, 32'hBF99_999A, 32'h3DCC_CCCD,
                            32'h4120_0000, 32'hC2C8_0000, 32'h3F7F_FFFF};
    logic [31:0] vb [6] = '{32'h402D_F854, 32'h4120_0000, 32'hBDCC_CCCD,
                            32'h3E80_0000, 32'h3FB5_04F3, 32'h3F7F_FFFF};
    int j = 0;
    out_ready = 1'b1;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      if (out_valid) begin
        if (j < 6) check("R7 R10 stream", out_result, ref_mul(va[j], vb[j]));
        j++;
      end
      if (c < 6) begin
        in_valid = 1'b1; in_a = va[c]; in_b = vb[c];
      end else begin
        in_valid = 1'b0;
      end
    end
    check("R7 back-to-back count", j, 32'd6);
  endtask

  task automatic t_backpressure();
    logic [31:0] x [3] = '{32'h4040_0000, 32'hC0A0_0000, 32'h3F40_0000};
    logic [31:0] y [3] = '{32'h4000_0000, 32'h3FC0_0000, 32'h4100_0000};
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_a = x[0]; in_b = y[0];
    @(negedge clk);
    in_a = x[1]; in_b = y[1];
    @(negedge clk);
    in_a = x[2]; in_b = y[2];
    check("R8 full blocks input", {31'h0, in_ready}, 32'h0);
    check("R8 head result", out_result, ref_mul(x[0], y[0]));
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R8 still blocked", {31'h0, in_ready}, 32'h0);
      check("R8 held valid", {31'h0, out_valid}, 32'h1);
      check("R8 held result", out_result, ref_mul(x[0], y[0]));
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 second out", out_result, ref_mul(x[1], y[1]));
    @(negedge clk);
    check("R10 third out", out_result, ref_mul(x[2], y[2]));
    @(negedge clk);
    check("R8 drained", {31'h0, out_valid}, 32'h0);
  endtask

  initial begin
    t_reset();
    t_zero();
    t_sign();
    t_exp_wrap();
    t_mant();
    t_norm();
    t_trunc();
    t_stream();
    t_backpressure();
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end
endmodule